// File: doc/BRIEF.md
# Single-Line Bus Request/Grant Arbiter

This block sits on the bus-owning side of a one-wire handshake. Another local master uses that handshake to borrow the local bus. Each channel is an active-low open-drain line. The other master pulls the line low for one clock to ask for the bus. This block answers by pulling the same line low for one clock. When the other master has finished, it pulls the line low for one more clock to hand the bus back. The line input is the resolved level of the wire, so the block's own grant pulse appears on it as well.

The bus sequencer reports the state of the current bus cycle on `phase_i` and a locked sequence on `lock_i`. A grant goes out only in a clock where the cycle is idle, in its last state (T4) or in its first state (T1), and only while no lock is in force. From the clock after the grant until the clock after the release, `floated_o` tells the sequencer to float its outputs, and `owner_o` names the channel that holds the bus. When two lines ask at once, the line with the lower index wins. The other request is remembered and is served after the bus comes back.

Top module: `rgarb_top`

## Requirements
- R1: While `rst` is high, and in the first clock after it, `floated_o` is 0 and no bit of `rg_drive_o` is 1.
- R2: A request is a low level on a line, sampled at a clock edge, while the bus is not lent. If the phase is idle (code 0) and `lock_i` is 0, the line's `rg_drive_o` bit is 1 for the whole clock that follows that edge.
- R3: A grant is given only in a clock whose `phase_i` is idle (0), T1 (1) or T4 (5). A request seen during T2 (2), T3 (3) or a wait state (4) is held, and its grant goes out in the first clock that shows one of the allowed codes.
- R4: While `lock_i` is 1, no grant is given. A held request is granted in the first allowed-phase clock with `lock_i` at 0.
- R5: `floated_o` is 1 from the clock after a grant pulse. `owner_o` then holds the granted channel index.
- R6: While `floated_o` is 1, no line is driven. A low on the owner's line is the release. `floated_o` is 0 from the clock after the clock in which the release was sampled.
- R7: When both lines request in the same clock, line 0 is granted first. Line 1 is granted in the first allowed clock after line 0 releases.
- R8: A grant pulse lasts exactly one clock, and at most one line is driven at any time.
- R9: A low on a line is not a new request in two cases: in the clock in which the block drives that line itself, and while that line's master owns the bus. After a release, that channel is not granted again until it sends a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_i | input | 3 | Bus-cycle state: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4 |
| lock_i | input | 1 | Locked sequence in progress; holds off grants |
| rg_line_i | input | NUM_CH | Resolved level of each request/grant line (low = pulse) |
| rg_drive_o | output | NUM_CH | Pull-down enable per line; 1 issues the grant pulse |
| floated_o | output | 1 | Bus lent out; the sequencer floats its outputs |
| owner_o | output | IDX_W | Index of the channel that holds the bus |

## Verification
The grant enable depends on the registered pending state and on the present phase and lock, so it appears in the clock after the request edge. That clock has no register in between, and the bench compares it in the same clock it applies that phase and lock. `floated_o` and `owner_o` are registered, so they change one edge after the grant or release clock. The bench models the wired line, applies every input just after a falling edge, compares all outputs with its own step model 1 ns later, and then advances that model by one rising edge. Directed sequences cover idle, phase-held, locked and simultaneous requests. A long seeded random run then mixes phases, locks, requests and releases.

// File: rtl/rgarb_pkg.sv
package rgarb_pkg;

    // Bus-cycle state as reported by the sequencer
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } bus_phase_e;

    localparam int PHASE_W = 3;

    // Ownership of the local bus
    typedef enum logic {
        CTL_FREE = 1'b0,
        CTL_LENT = 1'b1
    } ctl_state_e;

    // A grant may leave only at a cycle boundary (T4, next T1) or when idle,
    // and never inside a locked sequence.
    function automatic logic grant_window(input logic [PHASE_W-1:0] ph,
                                          input logic lk);
        return !lk && (ph == PH_IDLE || ph == PH_T1 || ph == PH_T4);
    endfunction

endpackage

// File: rtl/rgarb_sampler.sv
module rgarb_sampler #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] line_i,
    input  logic [NUM_CH-1:0] mask_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] pend_o
);

    // One pending latch per line; a low that is not masked is a request.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic pend_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= 1'b0;
            end else if (!line_i[g] && !mask_i[g]) begin
                pend_q <= 1'b1;
            end else if (clr_i[g]) begin
                pend_q <= 1'b0;
            end
        end
        assign pend_o[g] = pend_q;
    end

endmodule

// File: rtl/rgarb_pick.sv
module rgarb_pick #(
    parameter int NUM_CH = 2,
    parameter int IDX_W  = 1
) (
    input  logic [NUM_CH-1:0] pend_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  win_idx_o,
    output logic [NUM_CH-1:0] win_oh_o
);

    // Fixed priority: the lowest index wins.
    always_comb begin
        win_idx_o = '0;
        win_oh_o  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                win_idx_o = IDX_W'(i);
                win_oh_o  = NUM_CH'(1) << i;
            end
        end
    end

    assign any_o = |pend_i;

endmodule

// File: rtl/rgarb_ctrl.sv
module rgarb_ctrl
    import rgarb_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int IDX_W  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               lock_i,
    input  logic [NUM_CH-1:0]  line_i,
    input  logic               any_i,
    input  logic [IDX_W-1:0]   win_idx_i,
    input  logic [NUM_CH-1:0]  win_oh_i,
    output logic [NUM_CH-1:0]  drive_o,
    output logic [NUM_CH-1:0]  mask_o,
    output logic [NUM_CH-1:0]  clr_o,
    output logic               floated_o,
    output logic [IDX_W-1:0]   owner_o
);

    ctl_state_e       state_q;
    logic [IDX_W-1:0] owner_q;
    logic             grant;
    logic             release_seen;
    logic [NUM_CH-1:0] owner_oh;

    assign grant        = (state_q == CTL_FREE) && any_i && grant_window(phase_i, lock_i);
    assign owner_oh     = NUM_CH'(1) << owner_q;
    assign release_seen = (state_q == CTL_LENT) && !line_i[owner_q];

    assign drive_o = grant ? win_oh_i : '0;
    assign clr_o   = drive_o;
    // Lows caused by our own pulse, or by the owner, are not requests.
    assign mask_o  = (state_q == CTL_LENT) ? owner_oh : drive_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTL_FREE;
            owner_q <= '0;
        end else begin
            case (state_q)
                CTL_FREE: if (grant) begin
                    state_q <= CTL_LENT;
                    owner_q <= win_idx_i;
                end
                CTL_LENT: if (release_seen) begin
                    state_q <= CTL_FREE;
                end
                default: state_q <= CTL_FREE;
            endcase
        end
    end

    assign floated_o = (state_q == CTL_LENT);
    assign owner_o   = owner_q;

endmodule

// File: rtl/rgarb_top.sv
module rgarb_top
    import rgarb_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               lock_i,
    input  logic [NUM_CH-1:0]  rg_line_i,
    output logic [NUM_CH-1:0]  rg_drive_o,
    output logic               floated_o,
    output logic [IDX_W-1:0]   owner_o
);

    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] mask;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] win_oh;
    logic [IDX_W-1:0]  win_idx;
    logic              any_pend;

    rgarb_sampler #(.NUM_CH(NUM_CH)) u_samp (
        .clk    (clk),
        .rst    (rst),
        .line_i (rg_line_i),
        .mask_i (mask),
        .clr_i  (clr),
        .pend_o (pend)
    );

    rgarb_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .pend_i    (pend),
        .any_o     (any_pend),
        .win_idx_o (win_idx),
        .win_oh_o  (win_oh)
    );

    rgarb_ctrl #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .phase_i   (phase_i),
        .lock_i    (lock_i),
        .line_i    (rg_line_i),
        .any_i     (any_pend),
        .win_idx_i (win_idx),
        .win_oh_i  (win_oh),
        .drive_o   (rg_drive_o),
        .mask_o    (mask),
        .clr_o     (clr),
        .floated_o (floated_o),
        .owner_o   (owner_o)
    );

endmodule

// File: rtl/rgarb_chk.sv
module rgarb_chk
    import rgarb_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int IDX_W  = 1
) (
    input logic               clk,
    input logic               rst,
    input logic [PHASE_W-1:0] phase_i,
    input logic               lock_i,
    input logic [NUM_CH-1:0]  rg_line_i,
    input logic [NUM_CH-1:0]  rg_drive_o,
    input logic               floated_o,
    input logic [IDX_W-1:0]   owner_o
);

    // R1: bus is held by this side after reset
    a_r1_reset_owned: assert property (@(posedge clk)
        rst |=> (!floated_o && rg_drive_o == '0));

    // R3: grant only at a cycle boundary or in idle
    a_r3_grant_window: assert property (@(posedge clk) disable iff (rst)
        (|rg_drive_o) |-> (phase_i == PH_IDLE || phase_i == PH_T1 || phase_i == PH_T4));

    // R4: no grant inside a locked sequence
    a_r4_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (|rg_drive_o) |-> !lock_i);

    // R5: bus floated after the grant pulse
    a_r5_float_after_grant: assert property (@(posedge clk) disable iff (rst)
        (|rg_drive_o) |=> floated_o);

    // R6: nothing driven while lent; release returns the bus
    a_r6_quiet_when_lent: assert property (@(posedge clk) disable iff (rst)
        floated_o |-> (rg_drive_o == '0));
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (floated_o && !rg_line_i[owner_o]) |=> !floated_o);

    // R8: one line, one clock
    a_r8_one_line: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rg_drive_o));
    a_r8_one_clock: assert property (@(posedge clk) disable iff (rst)
        (|rg_drive_o) |=> (rg_drive_o == '0));

endmodule

bind rgarb_top rgarb_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .phase_i    (phase_i),
    .lock_i     (lock_i),
    .rg_line_i  (rg_line_i),
    .rg_drive_o (rg_drive_o),
    .floated_o  (floated_o),
    .owner_o    (owner_o)
);

// File: tb/sim_rgarb_top.sv
module sim_rgarb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] phase = 3'd0;
    logic       lock = 1'b0;
    logic [1:0] pull = 2'b00;
    logic [1:0] line;
    logic [1:0] drive;
    logic       floated;
    logic [0:0] owner;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    string tag = "R1";

    // Reference state
    logic [1:0] m_pend = 2'b00;
    logic       m_own  = 1'b0;
    int         m_owner = 0;

    always #4 clk = ~clk;

    assign line = ~(drive | pull);

    rgarb_top #(.NUM_CH(2)) u0 (
        .clk        (clk),
        .rst        (rst),
        .phase_i    (phase),
        .lock_i     (lock),
        .rg_line_i  (line),
        .rg_drive_o (drive),
        .floated_o  (floated),
        .owner_o    (owner)
    );

    function automatic logic [1:0] exp_drive(input logic own, input logic [1:0] pend,
                                             input logic [2:0] ph, input logic lk);
        if (own || pend == 2'b00 || lk) return 2'b00;
        if (!(ph == 3'd0 || ph == 3'd1 || ph == 3'd5)) return 2'b00;
        return pend[0] ? 2'b01 : 2'b10;
    endfunction

    // Apply inputs for one clock, compare, advance the model across the edge.
    task automatic step(input logic [2:0] ph, input logic lk, input logic [1:0] pl);
        logic [1:0] ed;
        logic [1:0] low;
        logic [1:0] np;
        phase = ph; lock = lk; pull = pl;
        #1;
        ed = rst ? 2'b00 : exp_drive(m_own, m_pend, ph, lk);
        n_chk++;
        if (drive !== ed || floated !== m_own || (m_own && int'(owner) != m_owner)) begin
            n_fail++;
            $display("FAIL %s: drive=%b exp %b floated=%b exp %b owner=%0d exp %0d",
                     tag, drive, ed, floated, m_own, owner, m_owner);
        end
        low = ed | pl;
        np  = m_pend & ~ed;
        for (int i = 0; i < 2; i++)
            if (low[i] && !ed[i] && !(m_own && m_owner == i)) np[i] = 1'b1;
        if (m_own) begin
            if (low[m_owner]) m_own = 1'b0;
        end else if (ed != 2'b00) begin
            m_own = 1'b1;
            m_owner = ed[0] ? 0 : 1;
        end
        m_pend = np;
        if (rst) begin
            m_pend = 2'b00; m_own = 1'b0; m_owner = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(3'd0, 1'b0, 2'b00);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        rst = 1'b1;
        step(3'd0, 1'b0, 2'b01);   // request during reset is discarded
        step(3'd0, 1'b0, 2'b00);
        rst = 1'b0;
        idle(2);                   // R1: still owned, nothing driven

        // R2 and R5: idle request, grant next clock, then floated with owner 0
        tag = "R2";
        step(3'd0, 1'b0, 2'b01);
        step(3'd0, 1'b0, 2'b00);   // expected grant on line 0
        tag = "R5";
        idle(3);
        // R6: release on line 0
        tag = "R6";
        step(3'd0, 1'b0, 2'b01);
        step(3'd0, 1'b0, 2'b00);   // floated drops here
        // R9: own grant low and release were not new requests
        tag = "R9";
        idle(4);

        // R3: request during T2, held through T3/wait, granted at T4
        tag = "R3";
        step(3'd2, 1'b0, 2'b10);
        step(3'd3, 1'b0, 2'b00);
        step(3'd4, 1'b0, 2'b00);
        step(3'd3, 1'b0, 2'b00);
        step(3'd5, 1'b0, 2'b00);   // grant line 1
        step(3'd0, 1'b0, 2'b00);
        step(3'd0, 1'b0, 2'b10);   // release
        idle(2);

        // R4: locked sequence holds a request off
        tag = "R4";
        step(3'd0, 1'b1, 2'b01);
        step(3'd0, 1'b1, 2'b00);
        step(3'd1, 1'b1, 2'b00);
        step(3'd5, 1'b1, 2'b00);
        step(3'd1, 1'b0, 2'b00);   // grant at T1 once unlocked
        step(3'd0, 1'b0, 2'b01);
        idle(2);

        // R7: simultaneous requests, line 0 first, line 1 after release
        tag = "R7";
        step(3'd0, 1'b0, 2'b11);
        step(3'd0, 1'b0, 2'b00);   // line 0
        step(3'd0, 1'b0, 2'b00);
        step(3'd2, 1'b0, 2'b01);   // release line 0 during T2
        step(3'd3, 1'b0, 2'b00);   // line 1 waits for window
        step(3'd5, 1'b0, 2'b00);   // line 1 granted
        step(3'd0, 1'b0, 2'b00);
        step(3'd0, 1'b0, 2'b10);
        idle(2);

        // R8: seeded random mix of phases, locks, requests and releases
        tag = "R8";
        void'($urandom(32'd2024));
        for (int c = 0; c < 4000; c++) begin
            logic [1:0] pl;
            logic [2:0] ph;
            pl = 2'b00;
            for (int i = 0; i < 2; i++) begin
                if (m_own && m_owner == i) pl[i] = ($urandom % 5) == 0;
                else pl[i] = ($urandom % 9) == 0;
            end
            ph = 3'($urandom % 6);
            step(ph, ($urandom % 4) == 0, pl);
        end
        idle(3);
        summary();
    end

endmodule